// File: doc/BRIEF.md
# Multichannel Digital Threshold Trigger

This block decides when to stop a switched-capacitor waveform sampler. Eight channels of that sampler run in pass-through mode, and an ADC digitizes their outputs without pause. Every clock cycle the block receives one sample per channel. It converts each sample to a signed value and compares it against one shared programmable level. The comparison direction is selectable, so the block can trigger on pulses that go either positive or negative. A channel fires only on the sample where it first crosses the level. The block counts the channels that fire in a cycle and raises a trigger when that count reaches a programmable multiplicity.

Two other sources are ORed with the channel trigger. One is an asynchronous external input, which is synchronized and edge-detected first. The other is a software request. Each trigger produces a one-cycle pulse and latches a mask of the channels that were beyond the level in that cycle. It also disarms the block until the acquisition controller asserts arm again. In auto mode the block forces a trigger after a programmable number of armed cycles without a hardware trigger. This gives periodic captures when no signal is present.

Top module: `mthr_trigger`

## Requirements
- R1: After reset, trig_pulse is 0, hit_mask is 0 and the block is disarmed, so no source can produce a trigger until arm has been seen high.
- R2: Each 14-bit sample is offset binary; inverting its MSB gives the two's-complement value. With neg_pol=0 a channel is beyond the level when its value is strictly greater than the signed level. With neg_pol=1 it is beyond the level when its value is strictly less. Equality never counts.
- R3: A channel fires only in the cycle where its beyond-level flag rises compared with its previous sample. A channel that stays beyond the level fires once, and a crossing that happens while the block is disarmed is not replayed later.
- R4: The channel trigger is true when the number of firing channels in a cycle is at least mult_min. A mult_min of 0 behaves as 1.
- R5: ext_in passes through two synchronizing flops and a rising-edge detector. A rise that arrives between clock edges yields a trigger pulse after the third rising clock edge that follows. Holding ext_in high yields only one trigger.
- R6: sw_trig sampled high at a clock edge while armed yields a trigger pulse after that edge.
- R7: The sources are ORed. When several sources are active in the same cycle, including an auto timeout, the block produces exactly one pulse.
- R8: trig_pulse is registered and lasts one cycle. For a crossing presented before clock edge k, the pulse is high after edge k.
- R9: On every trigger, hit_mask (bit i = channel i) loads the beyond-level flags of the trigger cycle. Between triggers it holds its value.
- R10: A trigger disarms the block. Samples, sw_trig and ext_in have no effect until arm is sampled high at a clock edge, which rearms the block from the next cycle.
- R11: With auto_mode=1 and the block armed at edge a, if no hardware trigger occurs, a forced pulse appears after edge a+T+1, where T = auto_timeout. With auto_mode=0 no forced trigger ever occurs.
- R12: A hardware trigger before the timeout cancels the pending forced trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samples | input | NCH*SW | Channel samples, channel i at bits i*SW+SW-1:i*SW, offset binary |
| level | input | SW | Signed threshold |
| neg_pol | input | 1 | 1 = fire when a sample drops below the level |
| mult_min | input | CW | Minimum number of firing channels |
| ext_in | input | 1 | Asynchronous external trigger |
| sw_trig | input | 1 | Software trigger request |
| arm | input | 1 | Rearm request from the acquisition controller |
| auto_mode | input | 1 | 1 = force a trigger after the timeout |
| auto_timeout | input | TW | Timeout in armed cycles |
| trig_pulse | output | 1 | One-cycle trigger |
| hit_mask | output | NCH | Channels beyond the level in the trigger cycle |

## Verification
The case of interest is an auto timeout and a real channel crossing that fall in the same cycle. The bench arms the block with a known timeout and steps to the exact cycle in which the timer equals that timeout. It then presents a crossing on one channel in that cycle. The result passes only if there is a single pulse at the predicted edge, hit_mask shows that one channel, and no second pulse follows. Separate sweeps cover each channel in both polarities and every multiplicity against every count of simultaneous crossings.

// File: rtl/mthr_trigger.sv
module mthr_trigger #(
  parameter int NCH = 8,
  parameter int SW  = 14,
  parameter int TW  = 16,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*SW-1:0]     samples,
  input  logic signed [SW-1:0]  level,
  input  logic                  neg_pol,
  input  logic [CW-1:0]         mult_min,
  input  logic                  ext_in,
  input  logic                  sw_trig,
  input  logic                  arm,
  input  logic                  auto_mode,
  input  logic [TW-1:0]         auto_timeout,
  output logic                  trig_pulse,
  output logic [NCH-1:0]        hit_mask
);

  logic [NCH-1:0] over, over_q, fire;
  logic [CW-1:0]  nfire;
  logic [2:0]     ext_q;
  logic [TW-1:0]  timer;
  logic           armed, mult_hit, ext_rise, force_t, take;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [SW-1:0] sval;
    assign sval    = {~samples[i*SW+SW-1], samples[i*SW +: SW-1]};
    assign over[i] = neg_pol ? (sval < level) : (sval > level);
  end

  assign fire = over & ~over_q;

  always_comb begin
    nfire = '0;
    for (int i = 0; i < NCH; i++) nfire = nfire + CW'(fire[i]);
  end

  assign mult_hit = (nfire != '0) && (nfire >= mult_min);
  assign ext_rise = ext_q[1] & ~ext_q[2];
  assign force_t  = auto_mode && (timer == auto_timeout);
  assign take     = armed && (mult_hit || ext_rise || sw_trig || force_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      over_q     <= '0;
      ext_q      <= '0;
      timer      <= '0;
      armed      <= 1'b0;
      trig_pulse <= 1'b0;
      hit_mask   <= '0;
    end else begin
      over_q     <= over;
      ext_q      <= {ext_q[1:0], ext_in};
      trig_pulse <= take;
      if (take) hit_mask <= over;
      armed <= take ? 1'b0 : (arm ? 1'b1 : armed);
      timer <= (armed && auto_mode && !take) ? timer + TW'(1) : '0;
    end
  end

endmodule

module mthr_trigger_chk #(
  parameter int TW = 16,
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig_pulse,
  input logic [NCH-1:0] hit_mask,
  input logic           sw_trig,
  input logic           arm,
  input logic           armed,
  input logic           auto_mode,
  input logic [TW-1:0]  timer,
  input logic [TW-1:0]  auto_timeout
);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_pulse |-> $stable(hit_mask));

  // R6
  sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sw_trig) |=> trig_pulse);

  // R10
  disarm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm) |=> !trig_pulse);

  // R11
  auto_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && auto_mode && timer == auto_timeout) |=> trig_pulse);

endmodule

bind mthr_trigger mthr_trigger_chk #(.TW(TW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_pulse(trig_pulse), .hit_mask(hit_mask),
  .sw_trig(sw_trig), .arm(arm), .armed(armed), .auto_mode(auto_mode),
  .timer(timer), .auto_timeout(auto_timeout)
);

// File: tb/mthr_trigger_tb.sv
module mthr_trigger_tb;
  localparam int NCH = 8;
  localparam int SW  = 14;
  localparam int TW  = 16;
  localparam int CW  = $clog2(NCH + 1);

  logic clk = 0, rst_n = 0;
  logic [NCH*SW-1:0] samples = '0;
  logic signed [SW-1:0] level = '0;
  logic neg_pol = 0, ext_in = 0, sw_trig = 0, arm = 0, auto_mode = 0;
  logic [CW-1:0] mult_min = '0;
  logic [TW-1:0] auto_timeout = '0;
  logic trig_pulse;
  logic [NCH-1:0] hit_mask;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mthr_trigger #(.NCH(NCH), .SW(SW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .samples(samples), .level(level),
    .neg_pol(neg_pol), .mult_min(mult_min), .ext_in(ext_in),
    .sw_trig(sw_trig), .arm(arm), .auto_mode(auto_mode),
    .auto_timeout(auto_timeout), .trig_pulse(trig_pulse), .hit_mask(hit_mask)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ch(int i, int v);
    logic [SW-1:0] t;
    t = SW'(v);
    samples[i*SW +: SW] = {~t[SW-1], t[SW-2:0]};
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < NCH; i++) set_ch(i, v);
  endtask

  task automatic do_arm();
    arm = 1; step(); arm = 0;
  endtask

  task automatic sw_pulse();
    sw_trig = 1; step(); sw_trig = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int quiet;
    set_all(0);
    level = SW'(100);
    mult_min = CW'(1);
    repeat (3) step();
    rst_n = 1;
    chk("R1 pulse", trig_pulse, 0);
    chk("R1 mask", hit_mask, 0);
    set_ch(0, 200); step();
    chk("R1 disarmed", trig_pulse, 0);
    set_ch(0, 0); step();

    // R2 R8 R9: positive polarity, each channel
    do_arm();
    for (int c = 0; c < NCH; c++) begin
      set_ch(c, 200); step();
      chk("R2 pos fire", trig_pulse, 1);
      chk("R9 mask", hit_mask, 32'(1 << c));
      step();
      chk("R8 one cycle", trig_pulse, 0);
      set_ch(c, 0); do_arm();
    end

    // R3: crossing while disarmed is lost, held level does not refire
    sw_pulse(); step();
    set_ch(0, 200); step();
    do_arm();
    quiet = 0;
    for (int j = 0; j < 3; j++) begin step(); quiet |= trig_pulse; end
    chk("R3 held level", quiet, 0);
    chk("R10 mask held", hit_mask, 0);
    set_ch(0, 0); step();

    // R2 equality boundary
    set_ch(3, 100); step();
    chk("R2 equal no fire", trig_pulse, 0);
    set_ch(3, 101); step();
    chk("R2 above fire", trig_pulse, 1);
    chk("R9 mask ch3", hit_mask, 8);
    set_ch(3, 0); step(); do_arm();

    // R2 negative polarity
    neg_pol = 1; level = -SW'(100);
    for (int c = 0; c < NCH; c++) begin
      set_ch(c, 8000); step();
      chk("R2 neg ignores positive", trig_pulse, 0);
      set_ch(c, -200); step();
      chk("R2 neg fire", trig_pulse, 1);
      chk("R9 neg mask", hit_mask, 32'(1 << c));
      set_ch(c, 0); step(); do_arm();
    end
    neg_pol = 0; level = SW'(100);
    step();

    // R4 multiplicity sweep
    for (int m = 0; m <= NCH; m++) begin
      for (int k = 1; k <= NCH; k++) begin
        int need;
        bit exp;
        need = (m == 0) ? 1 : m;
        exp = (k >= need);
        mult_min = CW'(m);
        for (int c = 0; c < k; c++) set_ch(c, 200);
        step();
        chk("R4 multiplicity", trig_pulse, exp);
        if (exp) chk("R9 multi mask", hit_mask, (32'(1) << k) - 1);
        set_all(0); step();
        if (exp) do_arm();
      end
    end
    mult_min = CW'(1);

    // R5 external trigger latency
    ext_in = 1;
    step(); chk("R5 edge1", trig_pulse, 0);
    step(); chk("R5 edge2", trig_pulse, 0);
    step(); chk("R5 edge3", trig_pulse, 1);
    chk("R9 ext mask", hit_mask, 0);
    step(); chk("R5 one pulse", trig_pulse, 0);
    do_arm();
    quiet = 0;
    for (int j = 0; j < 5; j++) begin step(); quiet |= trig_pulse; end
    chk("R5 held high", quiet, 0);
    ext_in = 0; repeat (3) step();
    ext_in = 1; step(); step(); step();
    chk("R5 second rise", trig_pulse, 1);
    ext_in = 0; step(); step(); do_arm();

    // R6 software trigger
    sw_pulse();
    chk("R6 sw", trig_pulse, 1);
    step(); chk("R8 sw one cycle", trig_pulse, 0);
    do_arm();

    // R7 simultaneous sources
    sw_trig = 1; set_ch(2, 200); step(); sw_trig = 0;
    chk("R7 combined", trig_pulse, 1);
    chk("R9 combined mask", hit_mask, 4);
    step(); chk("R7 single", trig_pulse, 0);
    set_ch(2, 0); step();

    // R10 disarmed inputs ignored
    sw_pulse(); chk("R10 sw ignored", trig_pulse, 0);
    set_ch(5, 200); step();
    chk("R10 cross ignored", trig_pulse, 0);
    chk("R10 mask unchanged", hit_mask, 4);
    set_ch(5, 0); step(); do_arm();

    // R11 auto timeout sweep
    for (int n = 0; n < 4; n++) begin
      int t;
      t = (n == 3) ? 9 : n;
      sw_pulse(); step();
      auto_mode = 1; auto_timeout = TW'(t);
      do_arm();
      quiet = 0;
      for (int j = 0; j < t; j++) begin step(); quiet |= trig_pulse; end
      chk("R11 early quiet", quiet, 0);
      step(); chk("R11 forced", trig_pulse, 1);
      chk("R9 forced mask", hit_mask, 0);
      step(); chk("R11 single", trig_pulse, 0);
    end

    // R11 normal mode never forces
    auto_mode = 0; auto_timeout = TW'(2);
    do_arm();
    quiet = 0;
    for (int j = 0; j < 40; j++) begin step(); quiet |= trig_pulse; end
    chk("R11 normal mode", quiet, 0);
    sw_pulse(); step();

    // R12 hardware trigger cancels timeout
    auto_mode = 1; auto_timeout = TW'(6);
    do_arm(); step(); step();
    set_ch(1, 200); step();
    chk("R12 hw first", trig_pulse, 1);
    chk("R9 hw mask", hit_mask, 2);
    set_ch(1, 0);
    quiet = 0;
    for (int j = 0; j < 10; j++) begin step(); quiet |= trig_pulse; end
    chk("R12 no forced", quiet, 0);

    // R7 R11 timeout coincides with channel crossing
    auto_timeout = TW'(4);
    do_arm();
    quiet = 0;
    for (int j = 0; j < 4; j++) begin step(); quiet |= trig_pulse; end
    chk("R11 coincide quiet", quiet, 0);
    set_ch(6, 200); step();
    chk("R7 coincide pulse", trig_pulse, 1);
    chk("R9 coincide mask", hit_mask, 32'h40);
    quiet = 0;
    for (int j = 0; j < 5; j++) begin step(); quiet |= trig_pulse; end
    chk("R7 coincide single", quiet, 0);
    set_ch(6, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule